// File: doc/BRIEF.md
# Serial BCD Fraction to Binary Converter

This block turns a four-digit decimal fraction, given as packed BCD digits that all sit to the right of the decimal point, into its binary fraction. It sends the binary fraction out one bit per clock, most significant bit first. Each step doubles the whole BCD fraction in place, digit by digit. The carry that leaves the tenths digit is the next binary digit, and the digits that remain hold the fractional part for the following step.

A conversion begins when a start pulse is seen while the block is idle. The BCD word and a bit budget (the precision) are captured at that edge. The block stops when the remaining fraction becomes zero or when the budget is spent, whichever comes first. It then gives a one-cycle done pulse, together with a flag that tells whether the binary result is exact or was cut short. There is no integer part, no sign and no rounding: bits beyond the budget are simply dropped.

Top module: `frac2bin_ser`

## Requirements
- R1: After reset, `bit_o`, `bit_vld_o`, `done_o` and `exact_o` are all low, and the block is idle.
- R2: The emitted bits follow repeated doubling of the fraction. Each bit is 1 exactly when the doubled fraction is at least 1.0, and only the fractional part is kept for the next step. Bits come out most significant first. Nibble `bcd_i[15:12]` is the tenths digit and `bcd_i[3:0]` is the ten-thousandths digit.
- R3: The first bit is valid on the second rising edge after the edge that accepted start. The following bits arrive on consecutive cycles, and `bit_vld_o` is high for exactly one cycle per bit.
- R4: When a step leaves the remaining fraction at zero, that step's bit is the last one.
- R5: At most the budgeted number of bits is emitted. The budget is `prec_i`, except that 0 counts as 1 and any value above 32 counts as 32.
- R6: `done_o` is a single-cycle pulse. It comes in the same cycle as the last valid bit. For a zero input it comes alone, on the second edge after the start edge, and no bits are emitted.
- R7: `exact_o` can be high only while `done_o` is high. It is high exactly when the remaining fraction is zero after the last bit; a zero input counts as exact.
- R8: A start pulse that arrives while a conversion is running is ignored, together with the `bcd_i` and `prec_i` presented with it. The running bit stream is unchanged, and no extra bits or done pulses follow.
- R9: Each BCD digit presented with an accepted start is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a conversion when the block is idle |
| bcd_i | input | 16 | Four packed BCD fraction digits, tenths digit in the top nibble |
| prec_i | input | 6 | Bit budget, 0 counts as 1, values above 32 count as 32 |
| bit_o | output | 1 | Serial binary fraction bit |
| bit_vld_o | output | 1 | `bit_o` is valid in this cycle |
| done_o | output | 1 | One-cycle pulse ending a conversion |
| exact_o | output | 1 | With `done_o`, the fraction reached zero |

## Verification
The assertions assume that every digit captured at an accepted start is a legal BCD digit, because the in-place doubling is only correct for digits 0 to 9. The stimulus never builds a BCD word directly. It takes integers from 0 to 9999 and splits them into decimal digits, so every word it presents is valid. This holds even for the word sent with a start pulse that is meant to be ignored while a conversion is running.

The precision sweep steps through 0 to 33, so the budget is clamped at both ends.

// File: rtl/frac_pkg.sv
package frac_pkg;
  localparam int unsigned DIGW = 4;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_t;
endpackage

// File: rtl/bcd_dbl_digit.sv
module bcd_dbl_digit
  import frac_pkg::*;
(
  input  logic [DIGW-1:0] d_i,
  input  logic            cin_i,
  output logic [DIGW-1:0] q_o,
  output logic            cout_o
);
  logic [DIGW:0] sum;

  always_comb begin
    sum    = {d_i, 1'b0} + {{DIGW{1'b0}}, cin_i};
    cout_o = (sum > 5'd9);
    // the +6 wraps modulo 16 and gives the same result as subtracting 10
    q_o    = cout_o ? (sum[DIGW-1:0] + 4'd6) : sum[DIGW-1:0];
  end
endmodule

// File: rtl/bcd_doubler.sv
module bcd_doubler
  import frac_pkg::*;
#(
  parameter int unsigned NDIG = 4
) (
  input  logic [NDIG*DIGW-1:0] frac_i,
  output logic [NDIG*DIGW-1:0] frac_o,
  output logic                 int_bit_o
);
  logic [NDIG:0] carry;

  assign carry[0] = 1'b0;

  // digit 0 is the least significant digit; the carry runs upward
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_dbl_digit u_dig (
      .d_i   (frac_i[g*DIGW +: DIGW]),
      .cin_i (carry[g]),
      .q_o   (frac_o[g*DIGW +: DIGW]),
      .cout_o(carry[g+1])
    );
  end

  assign int_bit_o = carry[NDIG];
endmodule

// File: rtl/frac_step_ctr.sv
module frac_step_ctr #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] limit_i,
  input  logic          dec_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= limit_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

  // R5
  budget_left_chk: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (cnt_q != '0));
  // R5
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/frac2bin_ser.sv
module frac2bin_ser
  import frac_pkg::*;
#(
  parameter int unsigned NDIG = 4,
  parameter int unsigned MAXB = 32,
  localparam int unsigned BW  = NDIG * DIGW,
  localparam int unsigned CW  = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [BW-1:0] bcd_i,
  input  logic [CW-1:0] prec_i,
  output logic          bit_o,
  output logic          bit_vld_o,
  output logic          done_o,
  output logic          exact_o
);
  localparam logic [CW-1:0] MAXB_C = CW'(MAXB);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  run_st_t       st_q;
  logic [BW-1:0] dig_q;
  logic [BW-1:0] dig_dbl;
  logic          step_bit;
  logic          dig_zero;
  logic          dbl_zero;
  logic          last_step;
  logic          accept;
  logic          step;
  logic [CW-1:0] limit;

  bcd_doubler #(.NDIG(NDIG)) u_dbl (
    .frac_i   (dig_q),
    .frac_o   (dig_dbl),
    .int_bit_o(step_bit)
  );

  always_comb begin
    if (prec_i == '0)        limit = ONE_C;
    else if (prec_i > MAXB_C) limit = MAXB_C;
    else                     limit = prec_i;
  end

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign dig_zero = (dig_q == '0);
  assign dbl_zero = (dig_dbl == '0);
  assign step     = (st_q == ST_RUN) && !dig_zero;

  frac_step_ctr #(.CW(CW)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .limit_i(limit),
    .dec_i  (step),
    .last_o (last_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      dig_q     <= '0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      done_o    <= 1'b0;
      exact_o   <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      done_o    <= 1'b0;
      exact_o   <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q  <= ST_RUN;
          dig_q <= bcd_i;
        end
      end else if (dig_zero) begin
        st_q    <= ST_IDLE;
        done_o  <= 1'b1;
        exact_o <= 1'b1;
      end else begin
        bit_o     <= step_bit;
        bit_vld_o <= 1'b1;
        dig_q     <= dig_dbl;
        if (dbl_zero || last_step) begin
          st_q    <= ST_IDLE;
          done_o  <= 1'b1;
          exact_o <= dbl_zero;
        end
      end
    end
  end

  function automatic logic bcd_legal(input logic [BW-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++)
      if (w[i*DIGW +: DIGW] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R9
  bcd_input_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> bcd_legal(bcd_i));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7
  exact_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    exact_o |-> done_o);
  // R3
  vld_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |-> $past(st_q == ST_RUN));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RUN) && start_i && !done_o) |=> (st_q == ST_RUN) || done_o);
  // R6
  done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (st_q == ST_IDLE));
endmodule

// File: tb/sim_frac2bin_ser.sv
module sim_frac2bin_ser;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [15:0] bcd_i = '0;
  logic [5:0] prec_i = '0;
  logic       bit_o, bit_vld_o, done_o, exact_o;
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  frac2bin_ser u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .bcd_i(bcd_i), .prec_i(prec_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .done_o(done_o), .exact_o(exact_o)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int v, input int p, input bit poke);
    int lim, r, en, got, donek, k;
    logic [31:0] eb, gb;
    bit ex, gex, tim_ok, seen_done;
    lim = (p == 0) ? 1 : (p > 32 ? 32 : p);
    r = v; en = 0; eb = '0;
    while (r != 0 && en < lim) begin
      r = r * 2;
      eb[31 - en] = (r >= 10000);
      if (r >= 10000) r = r - 10000;
      en++;
    end
    ex = (r == 0);
    @(negedge clk);
    bcd_i = to_bcd(v); prec_i = 6'(p); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; gb = '0; gex = 1'b0; tim_ok = 1'b1; seen_done = 1'b0; donek = -1;
    for (k = 0; k < 40 && !seen_done; k++) begin
      if (k == 0 && poke) begin
        bcd_i = to_bcd(1234); prec_i = 6'd7; start_i = 1'b1;
      end else start_i = 1'b0;
      if (bit_vld_o !== ((k >= 1) && (k <= en))) tim_ok = 1'b0;
      if (bit_vld_o) begin
        if (got < 32) gb[31 - got] = bit_o;
        got++;
      end
      if (done_o) begin
        seen_done = 1'b1; gex = exact_o; donek = k;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    // R5 R4: bit count
    check(got == en, "R5", got, en);
    // R2: bit values, MSB first
    check(gb == eb, "R2", gb, eb);
    // R7: exactness
    check(gex == ex, "R7", gex, ex);
    // R3: one bit per cycle, first on second edge after start
    check(tim_ok, "R3", tim_ok, 1);
    // R6: done timing
    check(donek == ((en == 0) ? 1 : en), "R6", donek, (en == 0) ? 1 : en);
    // R8: quiet after done, ignored start did not restart
    for (int q = 0; q < 3; q++) begin
      check(!bit_vld_o && !done_o, "R8", {bit_vld_o, done_o}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({bit_o, bit_vld_o, done_o, exact_o} == 4'b0, "R1",
          {bit_o, bit_vld_o, done_o, exact_o}, 0);
    run(5000, 1, 1'b0);   // R4 exact after one bit
    run(625, 4, 1'b0);    // R4 exact 0.0001
    run(625, 3, 1'b0);    // R5 truncated
    run(0, 5, 1'b0);      // R6 R7 zero input
    run(9999, 32, 1'b0);  // R5 full budget
    run(9999, 40, 1'b0);  // R5 clamp above 32
    run(3, 0, 1'b0);      // R5 zero budget counts as one
    run(1, 33, 1'b1);     // R8 start during run
    run(0, 0, 1'b1);      // R8 start during zero run
    for (int v = 0; v < 10000; v += 37)
      run(v, (v / 37) % 34, (v % 3) == 0);
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule